// File: doc/BRIEF.md
# I2C Byte Master Engine

This block is the bus-facing half of a master-only I2C/SMBus controller. A sequencer sends it one command at a time: START, WRITE a byte, READ a byte and answer ACK, READ a byte and answer NACK, or STOP. The engine produces the matching line activity on SCL and SDA. Both lines are open-drain, so the block shows its drive as two output enables. When the line is enabled it is pulled low; when it is disabled it is released.

Each operation ends with the engine keeping SCL low and raising a one-cycle event. At the same time it publishes an 8-bit code that says what just happened on the bus. The sequencer reads the code and picks the next command. The SCL rate comes from a quarter-period divider. With a 4 MHz system clock, the divider supports bit rates from 10 kHz to 100 kHz.

The engine owns the bus from a START until a STOP. During that time a counter watches how long SCL stays low. If SCL is low for too long, the engine gives up, releases both lines and reports a bus error. If the engine drives a 1 but reads back a 0, it reports lost arbitration and withdraws from the bus.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both line enables are low, busy and statusEvent are low, and statusCode reads 0xF8 (no event yet).
- R2: A START from idle pulls SDA low while SCL is high, then pulls SCL low. It then reports 0x08 and keeps SCL held low.
- R3: A WRITE shifts the byte out most significant bit first, one bit per SCL high period. On the ninth clock SDA is released and the ACK is sampled, where a low level means ACK.
- R4: The first WRITE after a START or repeated START is an address. If its bit 0 is 0, the code is 0x18 on ACK and 0x20 on NACK. If its bit 0 is 1, the code is 0x40 on ACK and 0x48 on NACK.
- R5: Any other WRITE reports 0x28 on ACK and 0x30 on NACK.
- R6: A READ releases SDA for eight clocks and builds rxData most significant bit first. On the ninth clock it drives SDA low for opcode 3 (ACK, code 0x50) or leaves it released for opcode 4 (NACK, code 0x58).
- R7: A START issued while the bus is held produces a repeated START. The engine reports 0x10 and treats the next WRITE as an address.
- R8: A STOP raises SDA while SCL is high. Both lines end up released and busy falls, with no status event.
- R9: If a transmitted 1 is sampled as 0, the engine reports 0x38, releases both lines on the following cycle and returns to idle.
- R10: While the engine owns the bus, SCL low for TIMEOUT_CYCLES clocks in a row reports 0x00 and releases both lines. Any high SCL restarts the count. SCL held low while idle reports nothing.
- R11: statusEvent is high for exactly one cycle per update of statusCode. The code never changes between events, and busy is low while the event is high.
- R12: cmdOp encodes 1 START, 2 WRITE, 3 READ+ACK, 4 READ+NACK and 5 STOP. Commands are taken only when busy is low. In idle only START is taken; other commands there change nothing.
- R13: Every SCL high period the engine generates lasts 2*QUARTER_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command opcode (see R12) |
| cmdData | input | 8 | Byte to send for WRITE |
| sclIn | input | 1 | Level sensed on SCL |
| sdaIn | input | 1 | Level sensed on SDA |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Operation in progress, commands not taken |
| statusEvent | output | 1 | One-cycle strobe on a new status code |
| statusCode | output | 8 | Last bus event code |
| rxData | output | 8 | Last byte received |

## Verification
The assertions assume that the sequencer never offers a command while busy is high, and they check that assumption as a property on cmdValid. The bench respects it by issuing every command only after the previous event has arrived, or after the bus has returned to idle. The bus model pulls SDA or SCL only while SCL is low, except when it deliberately forces arbitration loss. It also starts the stuck-SCL case only from idle, so every code the assertions see comes from a legal bus sequence.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam logic [2:0] OP_START     = 3'd1;
  localparam logic [2:0] OP_WRITE     = 3'd2;
  localparam logic [2:0] OP_READ_ACK  = 3'd3;
  localparam logic [2:0] OP_READ_NACK = 3'd4;
  localparam logic [2:0] OP_STOP      = 3'd5;

  localparam logic [7:0] SC_BUS_ERROR  = 8'h00;
  localparam logic [7:0] SC_START      = 8'h08;
  localparam logic [7:0] SC_RSTART     = 8'h10;
  localparam logic [7:0] SC_ADDR_W_ACK = 8'h18;
  localparam logic [7:0] SC_ADDR_W_NAK = 8'h20;
  localparam logic [7:0] SC_DATA_ACK   = 8'h28;
  localparam logic [7:0] SC_DATA_NAK   = 8'h30;
  localparam logic [7:0] SC_ARB_LOST   = 8'h38;
  localparam logic [7:0] SC_ADDR_R_ACK = 8'h40;
  localparam logic [7:0] SC_ADDR_R_NAK = 8'h48;
  localparam logic [7:0] SC_RX_ACK     = 8'h50;
  localparam logic [7:0] SC_RX_NAK     = 8'h58;
  localparam logic [7:0] SC_NONE       = 8'hF8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_START, ST_RSTART, ST_XFER, ST_STOP
  } engState_t;

  // control -> datapath
  typedef struct packed {
    logic run;        // slot counters advance
    logic loadTx;     // capture command byte
    logic shiftTx;    // advance transmit shifter
    logic captureRx;  // shift sampled SDA into receiver
    logic sclLow;     // requested SCL drive
    logic sdaLow;     // requested SDA drive
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic       sampleTick;
    logic       slotEnd;
    logic [1:0] phase;
    logic [3:0] bitIdx;
    logic       txMsb;
    logic       sdaBit;
    logic       timeout;
    logic       sdaOeNow;
  } dpFeedback_t;

endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int QUARTER_DIV    = 10,
  parameter int TIMEOUT_CYCLES = 100000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  stb,
  input  logic [7:0]  cmdData,
  input  logic        sclIn,
  input  logic        sdaIn,
  output dpFeedback_t fb,
  output logic        sclOe,
  output logic        sdaOe,
  output logic [7:0]  rxData
);

  localparam int DW = (QUARTER_DIV > 2) ? $clog2(QUARTER_DIV) : 1;
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [DW-1:0] DIV_LAST  = DW'(QUARTER_DIV - 1);
  localparam logic [TW-1:0] LOW_LIMIT = TW'(TIMEOUT_CYCLES);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic [DW-1:0] divCnt;
  logic [1:0]    phase;
  logic [3:0]    bitIdx;
  logic [7:0]    txShift;
  logic [7:0]    rxShift;
  logic [TW-1:0] lowCnt;
  logic          qTick;
  logic          sclSync;

  // input synchronisers (released level = 1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
    end
  end
  assign sclSync = sclPipe[SYNC_STAGES-1];

  // quarter-period divider, phase and bit counters
  assign qTick = stb.run && (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= '0;
      bitIdx <= '0;
    end else if (!stb.run) begin
      divCnt <= '0;
      phase  <= '0;
      bitIdx <= '0;
    end else if (qTick) begin
      divCnt <= '0;
      phase  <= phase + 2'd1;
      if (phase == 2'd3) bitIdx <= bitIdx + 4'd1;
    end else begin
      divCnt <= divCnt + DW'(1);
    end
  end

  // byte shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (stb.loadTx)       txShift <= cmdData;
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
      if (stb.captureRx)    rxShift <= {rxShift[6:0], sdaPipe[SYNC_STAGES-1]};
    end
  end

  // open-drain drive registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      sclOe <= stb.sclLow;
      sdaOe <= stb.sdaLow;
    end
  end

  // SCL-low watchdog: any high level restarts it, saturates at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lowCnt <= '0;
    else if (sclSync)           lowCnt <= '0;
    else if (lowCnt != LOW_LIMIT) lowCnt <= lowCnt + TW'(1);
  end

  assign rxData = rxShift;

  always_comb begin
    fb.sampleTick = qTick && (phase == 2'd2);
    fb.slotEnd    = qTick && (phase == 2'd3);
    fb.phase      = phase;
    fb.bitIdx     = bitIdx;
    fb.txMsb      = txShift[7];
    fb.sdaBit     = sdaPipe[SYNC_STAGES-1];
    fb.timeout    = (lowCnt == LOW_LIMIT);
    fb.sdaOeNow   = sdaOe;
  end

endmodule

// File: rtl/i2cm_control.sv
module i2cm_control
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic        dirBit,
  input  dpFeedback_t fb,
  output ctlStrobe_t  stb,
  output logic        busy,
  output logic        statusEvent,
  output logic [7:0]  statusCode
);

  engState_t state;
  logic isRead, ackOut, isAddr, addrRd, afterStart, ackSeen;
  logic cmdAccept, dataBit, ackBit, arbLost;

  assign dataBit = (fb.bitIdx < 4'd8);
  assign ackBit  = (fb.bitIdx == 4'd8);
  assign arbLost = fb.sampleTick && !isRead && dataBit && fb.txMsb && !fb.sdaBit;

  always_comb begin
    cmdAccept = cmdValid &&
                (((state == ST_IDLE) && (cmdOp == OP_START)) ||
                 ((state == ST_HOLD) && (cmdOp >= OP_START) && (cmdOp <= OP_STOP)));
  end

  always_comb begin
    stb  = '0;
    busy = 1'b1;
    case (state)
      ST_IDLE: begin
        busy = 1'b0;
      end
      ST_HOLD: begin
        busy       = 1'b0;
        stb.sclLow = 1'b1;
        stb.sdaLow = fb.sdaOeNow;
        stb.loadTx = cmdAccept && (cmdOp == OP_WRITE);
      end
      ST_START: begin
        stb.run    = 1'b1;
        stb.sdaLow = 1'b1;
        stb.sclLow = fb.phase[1];
      end
      ST_RSTART: begin
        stb.run    = 1'b1;
        stb.sclLow = (fb.phase == 2'd0) || (fb.phase == 2'd3);
        stb.sdaLow = fb.phase[1];
      end
      ST_STOP: begin
        stb.run    = 1'b1;
        stb.sclLow = (fb.phase == 2'd0);
        stb.sdaLow = !fb.phase[1];
      end
      ST_XFER: begin
        stb.run       = 1'b1;
        stb.sclLow    = (fb.phase == 2'd0) || (fb.phase == 2'd3);
        stb.sdaLow    = dataBit ? (!isRead && !fb.txMsb) : (isRead && ackOut);
        stb.shiftTx   = fb.slotEnd && !isRead && dataBit;
        stb.captureRx = fb.sampleTick && isRead && dataBit;
      end
      default: busy = 1'b0;
    endcase
  end

  function automatic logic [7:0] xferCode(input logic rd, input logic addr,
                                          input logic addrR, input logic ack,
                                          input logic ackDriven);
    if (rd)        return ackDriven ? SC_RX_ACK : SC_RX_NAK;
    else if (!addr) return ack ? SC_DATA_ACK : SC_DATA_NAK;
    else if (addrR) return ack ? SC_ADDR_R_ACK : SC_ADDR_R_NAK;
    else            return ack ? SC_ADDR_W_ACK : SC_ADDR_W_NAK;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      statusCode  <= SC_NONE;
      statusEvent <= 1'b0;
      isRead      <= 1'b0;
      ackOut      <= 1'b0;
      isAddr      <= 1'b0;
      addrRd      <= 1'b0;
      afterStart  <= 1'b0;
      ackSeen     <= 1'b0;
    end else begin
      statusEvent <= 1'b0;
      if ((state != ST_IDLE) && fb.timeout) begin
        state       <= ST_IDLE;
        statusCode  <= SC_BUS_ERROR;
        statusEvent <= 1'b1;
      end else begin
        case (state)
          ST_IDLE: if (cmdAccept) state <= ST_START;
          ST_HOLD: if (cmdAccept) begin
            case (cmdOp)
              OP_START: state <= ST_RSTART;
              OP_WRITE: begin
                state      <= ST_XFER;
                isRead     <= 1'b0;
                isAddr     <= afterStart;
                addrRd     <= dirBit;
                afterStart <= 1'b0;
              end
              OP_READ_ACK, OP_READ_NACK: begin
                state      <= ST_XFER;
                isRead     <= 1'b1;
                ackOut     <= (cmdOp == OP_READ_ACK);
                afterStart <= 1'b0;
              end
              default: state <= ST_STOP;
            endcase
          end
          ST_START, ST_RSTART: if (fb.slotEnd) begin
            state       <= ST_HOLD;
            statusCode  <= (state == ST_START) ? SC_START : SC_RSTART;
            statusEvent <= 1'b1;
            afterStart  <= 1'b1;
          end
          ST_STOP: if (fb.slotEnd) state <= ST_IDLE;
          ST_XFER: begin
            if (arbLost) begin
              state       <= ST_IDLE;
              statusCode  <= SC_ARB_LOST;
              statusEvent <= 1'b1;
            end else begin
              if (fb.sampleTick && ackBit) ackSeen <= !fb.sdaBit;
              if (fb.slotEnd && ackBit) begin
                state       <= ST_HOLD;
                statusCode  <= xferCode(isRead, isAddr, addrRd, ackSeen, ackOut);
                statusEvent <= 1'b1;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int QUARTER_DIV    = 10,
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [7:0] cmdData,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       busy,
  output logic       statusEvent,
  output logic [7:0] statusCode,
  output logic [7:0] rxData
);

  ctlStrobe_t  stb;
  dpFeedback_t fb;

  i2cm_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdOp       (cmdOp),
    .dirBit      (cmdData[0]),
    .fb          (fb),
    .stb         (stb),
    .busy        (busy),
    .statusEvent (statusEvent),
    .statusCode  (statusCode)
  );

  i2cm_datapath #(
    .QUARTER_DIV    (QUARTER_DIV),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .SYNC_STAGES    (2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cmdData (cmdData),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .fb      (fb),
    .sclOe   (sclOe),
    .sdaOe   (sdaOe),
    .rxData  (rxData)
  );

endmodule

// File: rtl/i2c_byte_master_checker.sv
module i2c_byte_master_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic       busy,
  input logic       statusEvent,
  input logic [7:0] statusCode,
  input logic       sclOe,
  input logic       sdaOe
);

  AST_CMD_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !busy); // R12

  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    statusEvent |=> !statusEvent); // R11

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !statusEvent |-> $stable(statusCode)); // R11

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    statusEvent |-> (statusCode[2:0] == 3'd0 && statusCode <= 8'h58)); // R11

  AST_EVENT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    statusEvent |-> !busy); // R11

  AST_RELEASE_ON_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (statusEvent && (statusCode == 8'h38 || statusCode == 8'h00)) |=> (!sclOe && !sdaOe)); // R9

  AST_HELD_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (statusEvent && statusCode != 8'h38 && statusCode != 8'h00) |-> sclOe); // R2

endmodule

bind i2c_byte_master i2c_byte_master_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .busy        (busy),
  .statusEvent (statusEvent),
  .statusCode  (statusCode),
  .sclOe       (sclOe),
  .sdaOe       (sdaOe)
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;

  localparam int QDIV = 4;
  localparam int TMO  = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [7:0] cmdData = '0;
  logic slaveSclLow = 1'b0;
  logic slaveSdaLow = 1'b0;
  logic sclOe, sdaOe, busy, statusEvent;
  logic [7:0] statusCode, rxData;
  wire sclLine = !(sclOe || slaveSclLow);
  wire sdaLine = !(sdaOe || slaveSdaLow);

  int checks = 0, failures = 0;
  int startCnt = 0, stopCnt = 0;
  bit done = 0;
  time tRise = 0, highLen = 0;

  always #10 clk = ~clk;

  i2c_byte_master #(.QUARTER_DIV(QDIV), .TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy),
    .statusEvent(statusEvent), .statusCode(statusCode), .rxData(rxData));

  always @(negedge sdaLine) if (sclLine === 1'b1 && rstN) startCnt++;
  always @(posedge sdaLine) if (sclLine === 1'b1 && rstN) stopCnt++;
  always @(posedge sclLine) tRise = $time;
  always @(negedge sclLine) highLen = $time - tRise;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [7:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // waits for an event; checks it lasts a single cycle (R11)
  task automatic waitEvent(int maxCyc, output bit got, output logic [7:0] code);
    got = 0; code = 8'hFF;
    for (int i = 0; i < maxCyc && !got; i++) begin
      @(negedge clk);
      if (statusEvent) begin
        got = 1; code = statusCode;
        @(negedge clk);
        chk("R11 event width", {31'd0, statusEvent}, 32'd0);
        chk("R11 code held", {24'd0, statusCode}, {24'd0, code});
      end
    end
  endtask

  task automatic doStart(logic [7:0] expCode, string req);
    bit got; logic [7:0] code; int s;
    s = startCnt;
    issue(3'd1, 8'h00);
    waitEvent(100, got, code);
    chk({req, " start event"}, {31'd0, got}, 32'd1);
    chk({req, " start code"}, {24'd0, code}, {24'd0, expCode});
    chk({req, " start condition seen"}, startCnt - s, 32'd1);
    chk("R2 SCL held", {31'd0, sclOe}, 32'd1);
  endtask

  task automatic doWrite(logic [7:0] data, bit slaveAck, logic [7:0] expCode, string req);
    bit got; logic [7:0] code; logic [7:0] seen; logic ackLvl;
    seen = '0;
    issue(3'd2, data);
    for (int i = 0; i < 8; i++) begin
      @(posedge sclLine);
      seen = {seen[6:0], sdaLine};
    end
    @(negedge sclLine);
    slaveSdaLow = slaveAck;
    @(posedge sclLine);
    ackLvl = sdaLine;
    @(negedge sclLine);
    slaveSdaLow = 1'b0;
    waitEvent(100, got, code);
    chk("R3 bits on wire", {24'd0, seen}, {24'd0, data});
    chk("R3 ack slot level", {31'd0, ackLvl}, {31'd0, !slaveAck});
    chk({req, " write code"}, {24'd0, code}, {24'd0, expCode});
  endtask

  task automatic doRead(logic [7:0] data, bit masterAck, logic [7:0] expCode);
    bit got; logic [7:0] code; logic ackLvl;
    slaveSdaLow = !data[7];
    issue(masterAck ? 3'd3 : 3'd4, 8'h00);
    for (int i = 0; i < 8; i++) begin
      @(negedge sclLine);
      slaveSdaLow = (i < 7) ? !data[6-i] : 1'b0;
    end
    @(posedge sclLine);
    ackLvl = sdaLine;
    waitEvent(100, got, code);
    chk("R6 read code", {24'd0, code}, {24'd0, expCode});
    chk("R6 rxData", {24'd0, rxData}, {24'd0, data});
    chk("R6 ack driven", {31'd0, ackLvl}, {31'd0, !masterAck});
  endtask

  task automatic doStop();
    bit got; logic [7:0] code; int s;
    s = stopCnt;
    issue(3'd5, 8'h00);
    waitEvent(4 * QDIV + 8, got, code);
    chk("R8 no event on stop", {31'd0, got}, 32'd0);
    chk("R8 stop condition seen", stopCnt - s, 32'd1);
    chk("R8 lines released", {30'd0, sclOe, sdaOe}, 32'd0);
    chk("R8 busy low", {31'd0, busy}, 32'd0);
  endtask

  task automatic testReset();
    chk("R1 sclOe", {31'd0, sclOe}, 32'd0);
    chk("R1 sdaOe", {31'd0, sdaOe}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 event", {31'd0, statusEvent}, 32'd0);
    chk("R1 code", {24'd0, statusCode}, 32'hF8);
  endtask

  task automatic testIdleIgnore();
    bit got; logic [7:0] code;
    issue(3'd2, 8'h55);
    issue(3'd5, 8'h00);
    issue(3'd3, 8'h00);
    waitEvent(40, got, code);
    chk("R12 no event in idle", {31'd0, got}, 32'd0);
    chk("R12 lines untouched", {30'd0, sclOe, sdaOe}, 32'd0);
    chk("R12 code unchanged", {24'd0, statusCode}, 32'hF8);
  endtask

  task automatic testLongTransfer();
    doStart(8'h08, "R2");
    doWrite(8'hA0, 1'b1, 8'h18, "R4");
    doWrite(8'h5A, 1'b1, 8'h28, "R5");
    doWrite(8'hC3, 1'b0, 8'h30, "R5");
    chk("R13 SCL high time", highLen, 2 * QDIV * 20);
    doStart(8'h10, "R7");
    doWrite(8'hA1, 1'b1, 8'h40, "R7");
    doRead(8'h3C, 1'b1, 8'h50);
    doRead(8'hE7, 1'b0, 8'h58);
    // well over TMO cycles with no bus error: count restarts on high SCL (R10)
    doStop();
  endtask

  task automatic testAddrNack();
    doStart(8'h08, "R2");
    doWrite(8'hA4, 1'b0, 8'h20, "R4");
    doStart(8'h10, "R7");
    doWrite(8'hA5, 1'b0, 8'h48, "R4");
    doStop();
  endtask

  task automatic testArbitration();
    bit got; logic [7:0] code;
    doStart(8'h08, "R2");
    slaveSdaLow = 1'b1;
    issue(3'd2, 8'hFF);
    waitEvent(100, got, code);
    chk("R9 arbitration code", {24'd0, code}, 32'h38);
    @(negedge clk); @(negedge clk);
    chk("R9 lines released", {30'd0, sclOe, sdaOe}, 32'd0);
    chk("R9 idle", {31'd0, busy}, 32'd0);
    slaveSdaLow = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic testTimeout();
    bit got; logic [7:0] code;
    doStart(8'h08, "R2");
    waitEvent(TMO + 100, got, code);
    chk("R10 timeout event", {31'd0, got}, 32'd1);
    chk("R10 timeout code", {24'd0, code}, 32'h00);
    @(negedge clk);
    chk("R10 lines released", {30'd0, sclOe, sdaOe}, 32'd0);
    repeat (5) @(negedge clk);
    slaveSclLow = 1'b1;
    waitEvent(TMO + 100, got, code);
    chk("R10 no timeout in idle", {31'd0, got}, 32'd0);
    slaveSclLow = 1'b0;
    repeat (5) @(negedge clk);
    doStart(8'h08, "R10 recovery");
    doStop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testIdleIgnore();
    testLongTransfer();
    testAddrNack();
    testArbitration();
    testTimeout();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule